// File: doc/BRIEF.md
# Byte-Wide SPI Master

This block is a single-channel SPI master that moves one byte at a time. Software programs a small register file through a simple byte-wide bus, loads a transmit byte and sets a start bit. The block then produces eight SCK cycles at a rate derived from the bus clock. On each data bit it drives MOSI and samples MISO, or samples its own MOSI when loopback is on. At the end of the byte it stores the received byte, raises a ready flag and drives the interrupt.

There is no buffering: exactly one byte is in flight, and each byte needs its own start and produces its own interrupt. Clock polarity, the sampling edge and bit order are chosen per transfer from the mode register. The phase-select bit has the opposite sense to the usual CPHA convention: when it is set, data is sampled on the leading SCK edge.

Register offsets: mode 0, receive data 1, transmit data 2, control 3, status 4, divisor 6. Offset 5 and 7 are unused and read as zero.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0x00, irq is 0, sck is 0 and no transfer is running.
- R2: Mode (offset 0, low five bits kept), transmit data (offset 2) and divisor (offset 6) read back what was written. Offsets 3, 5 and 7 read 0x00.
- R3: During a transfer, SCK makes exactly 16 transitions, each 2*(D+1) bus-clock cycles after the previous one and the first that long after the start write, where D is the divisor value. This gives an SCK frequency of f_clk/(4*(D+1)).
- R4: While no transfer runs, sck equals mode bit 1 (value 0x02, clock idles high when set).
- R5: With mode bit 4 (0x10) set, MISO is sampled on leading SCK edges and MOSI changes on trailing edges, with the first bit driven at the start. With it clear, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R6: With mode bit 2 (0x04) clear, bit 7 goes first on MOSI and the first received bit lands in bit 7. With it set, bit 0 goes first and the first received bit lands in bit 0.
- R7: With mode bit 0 (0x01) set, the receive shifter samples MOSI instead of MISO, so the received byte equals the transmitted byte.
- R8: Status bit 1 (0x02, busy) is set from the start write until one bus-clock cycle after the last SCK transition. In the same cycle that busy falls, status bit 0 (0x01, receive ready) becomes 1 and the received byte is readable at offset 1.
- R9: irq is high exactly while receive ready is set. A read of offset 1 clears receive ready and irq, unless a transfer completes in that same cycle.
- R10: A write of 0x01 to offset 3 starts a transfer only when mode bit 3 (0x08, enable) is set and busy is clear. Otherwise it has no effect: no SCK activity, and busy and the transfer in progress are unchanged.
- R11: While no transfer runs, MOSI holds the last bit driven, which is the last bit of the previous byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt, level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that software does not rewrite the mode register while busy is set. This matters because the SCK idle level, edge choice and bit order are taken live from that register. The stimulus honours this by programming mode, divisor and transmit data only between transfers, and by issuing extra start writes only as deliberate rejected requests. The bench also assumes the serial slave changes MISO only on the opposite edge to sampling, and its slave model acts on observed SCK transitions, so MISO is always stable at least two bus cycles before it is sampled.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MODE_W = 5;

  // register byte offsets
  localparam int unsigned OFS_MODE = 0;
  localparam int unsigned OFS_RXD  = 1;
  localparam int unsigned OFS_TXD  = 2;
  localparam int unsigned OFS_CTRL = 3;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_DIV  = 6;

  // mode field positions (value bit numbering, LSB = 0)
  localparam int unsigned MB_LOOP = 0;
  localparam int unsigned MB_CPOL = 1;
  localparam int unsigned MB_LSBF = 2;
  localparam int unsigned MB_EN   = 3;
  localparam int unsigned MB_LEAD = 4;

  // status and control positions
  localparam int unsigned SB_READY = 0;
  localparam int unsigned SB_BUSY  = 1;
  localparam int unsigned CB_GO    = 0;

  // byte lane carrying the k-th serial bit
  function automatic logic [2:0] lane_of(input logic lsb_first, input logic [2:0] k);
    return lsb_first ? k : (3'd7 - k);
  endfunction

  // bus cycles between SCK transitions: 2*(div+1)
  function automatic logic [9:0] half_len(input logic [7:0] div);
    return {1'b0, div, 1'b0} + 10'd2;
  endfunction
endpackage

// File: rtl/spi_byte_clkdiv.sv
module spi_byte_clkdiv
  import spi_byte_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int unsigned CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(half_len(8'(div))) - CNT_W'(1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_byte_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tick,
  input  logic [W-1:0] tx_byte,
  input  logic         lead_sample,
  input  logic         lsb_first,
  input  logic         loopback,
  input  logic         miso,
  output logic         active,
  output logic         shifting,
  output logic         done,
  output logic         sck_phase,
  output logic         mosi,
  output logic [W-1:0] rx_byte
);
  localparam int unsigned EDGES  = 2 * W;
  localparam int unsigned EDGE_W = $clog2(EDGES) + 1;

  logic [EDGE_W-1:0] edge_q;
  logic              run_q, drain_q, phase_q, mosi_q;
  logic [W-1:0]      txbuf_q, rxsh_q;

  logic              sample_now, last_edge, launch_past_end;
  logic [EDGE_W-1:0] launch_k;
  logic [2:0]        sample_lane, launch_lane;
  logic              serial_in;

  assign serial_in       = loopback ? mosi_q : miso;
  assign sample_now      = edge_q[0] ^ lead_sample;
  assign last_edge       = (edge_q == EDGE_W'(EDGES - 1));
  assign launch_k        = (edge_q + EDGE_W'(1)) >> 1;
  assign launch_past_end = (launch_k >= EDGE_W'(W));
  assign sample_lane     = lane_of(lsb_first, 3'(edge_q >> 1));
  assign launch_lane     = lane_of(lsb_first, 3'(launch_k));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q  <= '0;
      run_q   <= 1'b0;
      drain_q <= 1'b0;
      phase_q <= 1'b0;
      mosi_q  <= 1'b0;
      txbuf_q <= '0;
      rxsh_q  <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      drain_q <= 1'b0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      txbuf_q <= tx_byte;
      if (lead_sample) mosi_q <= tx_byte[lane_of(lsb_first, 3'd0)];
    end else if (run_q && tick) begin
      phase_q <= ~phase_q;
      edge_q  <= edge_q + EDGE_W'(1);
      if (sample_now)            rxsh_q[sample_lane] <= serial_in;
      else if (!launch_past_end) mosi_q <= txbuf_q[launch_lane];
      if (last_edge) begin
        run_q   <= 1'b0;
        drain_q <= 1'b1;
      end
    end else begin
      drain_q <= 1'b0;
    end
  end

  assign active    = run_q | drain_q;
  assign shifting  = run_q;
  assign done      = drain_q;
  assign sck_phase = phase_q;
  assign mosi      = mosi_q;
  assign rx_byte   = rxsh_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic [MODE_W-1:0] mode_q;
  logic [BYTE_W-1:0] txd_q, rxd_q;
  logic [DIV_W-1:0]  div_q;
  logic              ready_q;

  logic              busy, shifting, done, tick, sck_phase;
  logic [BYTE_W-1:0] rx_shift;
  logic              wr_mode, wr_txd, wr_div, go_req, start_ok, rx_read;

  assign wr_mode  = reg_wr && (reg_addr == ADDR_W'(OFS_MODE));
  assign wr_txd   = reg_wr && (reg_addr == ADDR_W'(OFS_TXD));
  assign wr_div   = reg_wr && (reg_addr == ADDR_W'(OFS_DIV));
  assign go_req   = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[CB_GO];
  assign start_ok = go_req && mode_q[MB_EN] && !busy;
  assign rx_read  = reg_rd && (reg_addr == ADDR_W'(OFS_RXD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      txd_q   <= '0;
      div_q   <= '0;
      rxd_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[MODE_W-1:0];
      if (wr_txd)  txd_q  <= reg_wdata;
      if (wr_div)  div_q  <= reg_wdata[DIV_W-1:0];
      if (done) begin
        rxd_q   <= rx_shift;
        ready_q <= 1'b1;
      end else if (rx_read) begin
        ready_q <= 1'b0;
      end
    end
  end

  spi_byte_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (shifting),
    .div  (div_q),
    .tick (tick)
  );

  spi_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_ok),
    .tick       (tick),
    .tx_byte    (txd_q),
    .lead_sample(mode_q[MB_LEAD]),
    .lsb_first  (mode_q[MB_LSBF]),
    .loopback   (mode_q[MB_LOOP]),
    .miso       (miso),
    .active     (busy),
    .shifting   (shifting),
    .done       (done),
    .sck_phase  (sck_phase),
    .mosi       (mosi),
    .rx_byte    (rx_shift)
  );

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      ADDR_W'(OFS_MODE): reg_rdata = 8'(mode_q);
      ADDR_W'(OFS_RXD):  reg_rdata = rxd_q;
      ADDR_W'(OFS_TXD):  reg_rdata = txd_q;
      ADDR_W'(OFS_STAT): begin
        reg_rdata[SB_BUSY]  = busy;
        reg_rdata[SB_READY] = ready_q;
      end
      ADDR_W'(OFS_DIV):  reg_rdata = 8'(div_q);
      default:           reg_rdata = 8'h00;
    endcase
  end

  assign irq = ready_q;
  assign sck = mode_q[MB_CPOL] ^ sck_phase;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_byte_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              irq,
  input logic              sck,
  input logic              mosi,
  input logic              busy,
  input logic              done,
  input logic              ready_q,
  input logic [MODE_W-1:0] mode_q,
  input logic [DIV_W-1:0]  div_q
);
  logic        sck_prev_q, seen_q, sck_chg, go_wr, rx_rd;
  logic [10:0] gap_q;

  assign sck_chg = (sck != sck_prev_q);
  assign go_wr   = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[CB_GO];
  assign rx_rd   = reg_rd && (reg_addr == ADDR_W'(OFS_RXD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      seen_q     <= 1'b0;
      gap_q      <= 11'd1;
    end else begin
      sck_prev_q <= sck;
      gap_q      <= sck_chg ? 11'd1 : gap_q + 11'd1;
      seen_q     <= busy ? (seen_q | sck_chg) : 1'b0;
    end
  end

  a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sck_chg && seen_q) |-> (gap_q == 11'(half_len(8'(div_q)))));

  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == mode_q[MB_CPOL]));

  a_r8_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ready_q);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !done) |=> !irq);

  a_r9_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq);

  a_r10_disabled_start: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !mode_q[MB_EN] && !busy) |=> !busy);

  a_r11_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(mosi));
endmodule

bind spi_byte_master spi_byte_master_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .irq      (irq),
  .sck      (sck),
  .mosi     (mosi),
  .busy     (busy),
  .done     (done),
  .ready_q  (ready_q),
  .mode_q   (mode_q),
  .div_q    (div_q)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  function automatic int exp_gap(input int d);
    return 2 * d + 2;
  endfunction

  function automatic int lane(input bit lsbf, input int k);
    return lsbf ? k : (7 ^ k);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input bit side, output int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_rd = side;
    #1 d = int'(reg_rdata);
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic xfer(input bit lead, input bit lsbf, input bit cpol, input bit loopb,
                      input int d, input int txb, input int slb, input bit inject);
    int n, last_n, e, edges, badgap, cap, v, k;
    bit prev, pend, got_end;
    wr(0, {3'b0, lead, 1'b1, lsbf, cpol, loopb});
    wr(6, d);
    wr(2, txb);
    check("R4 idle sck before start", int'(sck), int'(cpol));
    if (lead) miso = slb[lane(lsbf, 0)];
    wr(3, 1);
    reg_addr = 3'd4;
    n = 0; last_n = 0; edges = 0; badgap = 0; cap = 0; prev = cpol; pend = 0; got_end = 0;
    while (n < 4000) begin
      @(negedge clk);
      if (pend) begin reg_wr = 1'b0; reg_addr = 3'd4; pend = 0; end
      #1 n++;
      if (sck != prev) begin
        e = edges; edges++;
        if (n - last_n != exp_gap(d)) badgap++;
        last_n = n;
        if (e[0] != lead) cap[lane(lsbf, e / 2)] = mosi;
        else begin
          k = (e + 1) / 2;
          if (k < 8) miso = slb[lane(lsbf, k)];
        end
        if (inject && e == 5) begin
          reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h01; pend = 1;
        end
      end
      prev = sck;
      if (!pend && reg_rdata[1] == 1'b0) begin got_end = 1; break; end
    end
    check("R3 edge count", edges, 16);
    check("R3 edge spacing errors", badgap, 0);
    check("R8 busy drop delay", n - last_n, 1);
    check("R8 status at end", int'(reg_rdata), 8'h01);
    check("R9 irq with ready", int'(irq), 1);
    check("R4 idle sck after end", int'(sck), int'(cpol));
    check("R5 R6 mosi byte", cap, txb);
    check("R11 mosi last bit", int'(mosi), int'(txb[lane(lsbf, 7)]));
    rd(1, 1'b1, v);
    check(loopb ? "R7 loopback rx" : "R5 R6 rx byte", v, loopb ? txb : slb);
    check("R9 irq cleared by read", int'(irq), 0);
    repeat (exp_gap(d) + 4) @(negedge clk);
    check("R10 no extra activity", int'(sck), int'(cpol));
    check("R11 mosi holds", int'(mosi), int'(txb[lane(lsbf, 7)]));
    if (!got_end) check("R8 transfer ended", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 irq", int'(irq), 0);
    check("R1 sck", int'(sck), 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, 1'b0, v);
      check("R1 register reset", v, 0);
    end
    // R2: readback and unused offsets
    wr(0, 8'hF7); rd(0, 1'b0, v); check("R2 mode readback", v, 8'h17);
    wr(2, 8'hA5); rd(2, 1'b0, v); check("R2 txd readback", v, 8'hA5);
    wr(6, 8'h3C); rd(6, 1'b0, v); check("R2 div readback", v, 8'h3C);
    wr(5, 8'hFF); rd(5, 1'b0, v); check("R2 unused reads zero", v, 0);
    rd(7, 1'b0, v); check("R2 offset 7 reads zero", v, 0);
    rd(3, 1'b0, v); check("R2 control reads zero", v, 0);
    // R10: start with port disabled
    wr(0, 8'h12);
    wr(6, 0);
    wr(3, 1);
    repeat (8) @(negedge clk);
    rd(4, 1'b0, v); check("R10 disabled start busy", v, 0);
    check("R10 disabled start sck", int'(sck), 1);
    check("R10 disabled start irq", int'(irq), 0);
    // directed corners
    xfer(1, 0, 0, 0, 0, 8'h81, 8'h5A, 0);
    xfer(0, 0, 0, 0, 0, 8'h3C, 8'hC3, 0);
    xfer(1, 1, 1, 0, 1, 8'h01, 8'h80, 0);
    xfer(0, 1, 1, 0, 2, 8'hFE, 8'h7F, 0);
    xfer(1, 0, 0, 1, 0, 8'h96, 8'h00, 0);
    xfer(0, 1, 0, 1, 1, 8'h4B, 8'hFF, 1);
    xfer(1, 1, 0, 0, 20, 8'hE2, 8'h1D, 1);
    // constrained random transfers
    for (int i = 0; i < 20; i++) begin
      bit lead, lsbf, cpol, loopb, inj;
      int d, t, s;
      lead  = 1'($urandom);
      lsbf  = 1'($urandom);
      cpol  = 1'($urandom);
      loopb = ($urandom % 4) == 0;
      inj   = ($urandom % 3) == 0;
      d = int'($urandom % 4);
      t = int'($urandom & 8'hFF);
      s = int'($urandom & 8'hFF);
      xfer(lead, lsbf, cpol, loopb, d, t, s, inj);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule